// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter Pair

This block holds two timer/counters, numbered 0 and 1. Each one is built from a low byte and a high byte and has its own 2-bit mode select, gate-enable bit, gate input pin and count pulse. A count pulse can be a prescaled clock tick or an external edge that has already been synchronized. The block supports two modes. Mode `00` is a gated 13-bit counter. Mode `11` splits timer 0 into two independent 8-bit counters and freezes timer 1. Modes `01` and `10` are not implemented, and a timer set to either of them holds its count.

Software reaches the block through an 8-bit control byte and a byte-wide counter load port. The control byte holds the two run bits and the two overflow flags. An overflow sets a timer's flag. Software can clear a flag by writing the control byte, and an interrupt acknowledge also clears it. A hardware set in the same cycle wins over both. The counter values and the flags can be read on the outputs at all times.

Top module: `dual_tmr_unit`

## Requirements
- R1: After reset both counts are 0 and `ctl_rdata` reads 8'h00.
- R2: In mode 00 the count value is {high byte, low byte bits 4:0}. Each enabled pulse adds 1 to this value. Bits 7:5 of the low byte do not change.
- R3: In mode 00, an enabled pulse at value 13'h1FFF wraps the count to 0 and sets the timer's flag on the same clock edge. Timer 0 uses `ctl_rdata` bit 5 and `t0_flag`. Timer 1 uses bit 7 and `t1_flag`.
- R4: A timer counts a pulse only when its run bit is 1 and either its gate-enable is 0 or its pin is 1.
- R5: Timer 1 holds its count whenever its mode is not 00. This covers mode 11.
- R6: When timer 0 is in mode 11, its low byte is an 8-bit counter that uses timer 0's pulse, run bit and gating. Wrapping from FF to 00 sets timer 0's flag.
- R7: When timer 0 is in mode 11, its high byte is an 8-bit counter. It advances on timer 0's pulse when timer 1's run bit is 1, and it ignores gating. Wrapping from FF to 00 sets timer 1's flag.
- R8: An acknowledge pulse clears the timer's flag one edge later, unless a hardware set happens in the same cycle.
- R9: A control write loads the timer 1 flag from bit 7, timer 1 run from bit 6, timer 0 flag from bit 5 and timer 0 run from bit 4. Bits 3:0 always read 0.
- R10: A hardware overflow set in the same cycle as a software write of 0 to that flag leaves the flag at 1.
- R11: Timer 0 holds both of its bytes in modes 01 and 10.
- R12: A counter write loads the byte picked by `cnt_sel`: 0 is timer 0 low, 1 is timer 0 high, 2 is timer 1 low, 3 is timer 1 high. The write takes priority over counting in the same cycle. In mode 00, a write to either byte of a timer suppresses that timer's count for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte: flags and run bits |
| cnt_wr | input | 1 | Write strobe for a counter byte |
| cnt_sel | input | 2 | Selects which counter byte is written |
| cnt_wdata | input | 8 | Counter byte write data |
| t0_mode | input | 2 | Timer 0 mode select |
| t1_mode | input | 2 | Timer 1 mode select |
| t0_gate_en | input | 1 | Timer 0 gating enable |
| t1_gate_en | input | 1 | Timer 1 gating enable |
| t0_pin | input | 1 | Timer 0 gate input level |
| t1_pin | input | 1 | Timer 1 gate input level |
| t0_tick | input | 1 | Timer 0 count pulse |
| t1_tick | input | 1 | Timer 1 count pulse |
| t0_ack | input | 1 | Timer 0 interrupt acknowledge |
| t1_ack | input | 1 | Timer 1 interrupt acknowledge |
| t0_count | output | 16 | Timer 0 {high, low} bytes |
| t1_count | output | 16 | Timer 1 {high, low} bytes |
| t0_flag | output | 1 | Timer 0 overflow flag |
| t1_flag | output | 1 | Timer 1 overflow flag |

## Verification
Each result is due on the first clock edge that samples its cause. This applies to count steps, wraps, flag sets, acknowledges, control writes and counter writes. No result takes a second cycle. The bench drives all inputs 1 ns after a rising edge and reads the outputs 1 ns after the next rising edge, so each check sees exactly one edge of effect. The bench runs a full 8192-step sweep in mode 00, all eight run/gate/pin combinations, and a 300-step split-mode sweep. It computes the expected counts and flags arithmetically from the number of enabled pulses.

// File: rtl/tmr_pkg.sv
// Package: shared constants and the mode encoding for the dual timer block.
// Assumes: byte-wide counter halves and an 8-bit control byte.
package tmr_pkg;
    localparam int BYTE_W = 8;   // width of each counter half
    localparam int PRE_W  = 5;   // low-byte bits used in the 13-bit mode

    typedef enum logic [1:0] {
        MODE_13B    = 2'b00,
        MODE_RSV_A  = 2'b01,
        MODE_RSV_B  = 2'b10,
        MODE_SPLIT  = 2'b11
    } tmr_mode_e;

    // Control byte bit positions (software decodes these).
    localparam int CTL_FLAG1 = 7;
    localparam int CTL_RUN1  = 6;
    localparam int CTL_FLAG0 = 5;
    localparam int CTL_RUN0  = 4;
endpackage

// File: rtl/tmr_gate.sv
// Module: tmr_gate
// Decides whether a timer counts: run must be 1, and gating must be off
// or the gate pin must be high. Purely combinational.
module tmr_gate (
    input  logic run,
    input  logic gate_en,
    input  logic pin,
    output logic cnt_en
);
    // Combine the run bit with the optional pin qualifier.
    always_comb cnt_en = run & (~gate_en | pin);
endmodule

// File: rtl/tmr_flag.sv
// Module: tmr_flag
// One overflow flag. A hardware set wins over a software write, and a
// software write wins over an acknowledge.
// Assumes: all inputs are synchronous to clk.
module tmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_wr,
    input  logic sw_val,
    input  logic ack,
    output logic flag_q
);
    // Update the flag in priority order: set, write, acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (hw_set) flag_q <= 1'b1;
        else if (sw_wr)  flag_q <= sw_val;
        else if (ack)    flag_q <= 1'b0;
    end

    // R10, R3
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> flag_q);

    // R8
    flag_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hw_set && !sw_wr) |=> !flag_q);

    // R9
    flag_sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !hw_set) |=> (flag_q == $past(sw_val)));
endmodule

// File: rtl/tmr_pair_cnt.sv
// Module: tmr_pair_cnt
// One timer's two counter bytes. When split is 0, the high byte and the
// low PRE_W bits of the low byte form one chained counter driven by
// inc_lo, and the low byte's upper bits are untouched. When split is 1,
// each byte counts on its own increment. A byte write wins over counting.
// Assumes: inc_* already include run and gate qualification.
module tmr_pair_cnt #(
    parameter int BYTE_W = tmr_pkg::BYTE_W,
    parameter int PRE_W  = tmr_pkg::PRE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              split,
    input  logic              inc_lo,
    input  logic              inc_hi,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] lo_q,
    output logic [BYTE_W-1:0] hi_q,
    output logic              ovf_wide,
    output logic              ovf_lo,
    output logic              ovf_hi
);
    localparam logic [PRE_W-1:0]  PRE_ONE  = PRE_W'(1);
    localparam logic [BYTE_W-1:0] BYTE_ONE = BYTE_W'(1);

    logic              pre_full, lo_full, hi_full;
    logic              step_wide, step_lo, step_hi;
    logic [PRE_W-1:0]  pre_inc;
    logic [BYTE_W-1:0] lo_d, hi_d;

    // Detect the all-ones states that produce carries.
    always_comb begin
        pre_full = (lo_q[PRE_W-1:0] == '1);
        lo_full  = (lo_q == '1);
        hi_full  = (hi_q == '1);
        pre_inc  = lo_q[PRE_W-1:0] + PRE_ONE;
    end

    // Qualify the count steps by mode and by any byte write this cycle.
    always_comb begin
        step_wide = ~split & inc_lo & ~wr_lo & ~wr_hi;
        step_lo   =  split & inc_lo & ~wr_lo;
        step_hi   =  split & inc_hi & ~wr_hi;
        ovf_wide  = step_wide & pre_full & hi_full;
        ovf_lo    = step_lo & lo_full;
        ovf_hi    = step_hi & hi_full;
    end

    // Work out the next byte values from writes and steps.
    always_comb begin
        lo_d = lo_q;
        hi_d = hi_q;
        if (wr_lo) lo_d = wdata;
        if (wr_hi) hi_d = wdata;
        if (step_wide) begin
            lo_d = {lo_q[BYTE_W-1:PRE_W], pre_inc};
            if (pre_full) hi_d = hi_q + BYTE_ONE;
        end
        if (step_lo) lo_d = lo_q + BYTE_ONE;
        if (step_hi) hi_d = hi_q + BYTE_ONE;
    end

    // Register both bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    // R2
    pre_upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!split && !wr_lo) |=> (lo_q[BYTE_W-1:PRE_W] == $past(lo_q[BYTE_W-1:PRE_W])));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_lo && !inc_hi && !wr_lo && !wr_hi) |=> ($stable(lo_q) && $stable(hi_q)));

    // R12
    byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (lo_q == $past(wdata)));

    // R3
    wide_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_wide |=> (hi_q == '0 && lo_q[PRE_W-1:0] == '0));
endmodule

// File: rtl/dual_tmr_unit.sv
// Module: dual_tmr_unit (top)
// Two timer/counters with a shared control byte. Mode 00 is a gated 13-bit
// counter. In mode 11, timer 0 splits into two 8-bit counters: the high one
// uses timer 1's run bit and flag, and timer 1 holds its count. Modes 01
// and 10 hold the count.
// Assumes: tick and pin inputs are already synchronous to clk.
module dual_tmr_unit #(
    parameter int BYTE_W = tmr_pkg::BYTE_W,
    parameter int PRE_W  = tmr_pkg::PRE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic [7:0]          ctl_wdata,
    output logic [7:0]          ctl_rdata,
    input  logic                cnt_wr,
    input  logic [1:0]          cnt_sel,
    input  logic [BYTE_W-1:0]   cnt_wdata,
    input  logic [1:0]          t0_mode,
    input  logic [1:0]          t1_mode,
    input  logic                t0_gate_en,
    input  logic                t1_gate_en,
    input  logic                t0_pin,
    input  logic                t1_pin,
    input  logic                t0_tick,
    input  logic                t1_tick,
    input  logic                t0_ack,
    input  logic                t1_ack,
    output logic [2*BYTE_W-1:0] t0_count,
    output logic [2*BYTE_W-1:0] t1_count,
    output logic                t0_flag,
    output logic                t1_flag
);
    import tmr_pkg::*;

    localparam int NTMR = 2;

    logic              run0_q, run1_q;
    logic [NTMR-1:0]   cnt_en, split, inc_lo, inc_hi, wr_lo, wr_hi;
    logic [NTMR-1:0]   ovf_wide, ovf_lo, ovf_hi, set_flag;
    logic [BYTE_W-1:0] lo_q [NTMR];
    logic [BYTE_W-1:0] hi_q [NTMR];
    logic              t0_split;

    // Hold the two run bits, loaded by control writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run0_q <= 1'b0;
            run1_q <= 1'b0;
        end else if (ctl_wr) begin
            run0_q <= ctl_wdata[CTL_RUN0];
            run1_q <= ctl_wdata[CTL_RUN1];
        end
    end

    tmr_gate u_gate0 (.run(run0_q), .gate_en(t0_gate_en), .pin(t0_pin), .cnt_en(cnt_en[0]));
    tmr_gate u_gate1 (.run(run1_q), .gate_en(t1_gate_en), .pin(t1_pin), .cnt_en(cnt_en[1]));

    // Route pulses by mode: only 00 counts wide, and only timer 0 splits.
    always_comb begin
        t0_split  = (t0_mode == MODE_SPLIT);
        split[0]  = t0_split;
        split[1]  = 1'b0;
        inc_lo[0] = t0_tick & cnt_en[0] & ((t0_mode == MODE_13B) | t0_split);
        inc_hi[0] = t0_tick & run1_q & t0_split;
        inc_lo[1] = t1_tick & cnt_en[1] & (t1_mode == MODE_13B);
        inc_hi[1] = 1'b0;
    end

    // Decode the byte-select into per-timer write strobes.
    always_comb begin
        for (int t = 0; t < NTMR; t++) begin
            wr_lo[t] = cnt_wr & (cnt_sel == 2'(2*t));
            wr_hi[t] = cnt_wr & (cnt_sel == 2'(2*t + 1));
        end
    end

    for (genvar g = 0; g < NTMR; g++) begin : g_tmr
        tmr_pair_cnt #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .split(split[g]),
            .inc_lo(inc_lo[g]), .inc_hi(inc_hi[g]),
            .wr_lo(wr_lo[g]), .wr_hi(wr_hi[g]), .wdata(cnt_wdata),
            .lo_q(lo_q[g]), .hi_q(hi_q[g]),
            .ovf_wide(ovf_wide[g]), .ovf_lo(ovf_lo[g]), .ovf_hi(ovf_hi[g])
        );
    end

    // Collect the overflow sources for each flag.
    always_comb begin
        set_flag[0] = ovf_wide[0] | ovf_lo[0];
        set_flag[1] = ovf_wide[1] | ovf_hi[0];
    end

    tmr_flag u_flag0 (
        .clk(clk), .rst_n(rst_n), .hw_set(set_flag[0]), .sw_wr(ctl_wr),
        .sw_val(ctl_wdata[CTL_FLAG0]), .ack(t0_ack), .flag_q(t0_flag)
    );
    tmr_flag u_flag1 (
        .clk(clk), .rst_n(rst_n), .hw_set(set_flag[1]), .sw_wr(ctl_wr),
        .sw_val(ctl_wdata[CTL_FLAG1]), .ack(t1_ack), .flag_q(t1_flag)
    );

    // Present the counts and the control byte.
    always_comb begin
        t0_count  = {hi_q[0], lo_q[0]};
        t1_count  = {hi_q[1], lo_q[1]};
        ctl_rdata = '0;
        ctl_rdata[CTL_FLAG1] = t1_flag;
        ctl_rdata[CTL_RUN1]  = run1_q;
        ctl_rdata[CTL_FLAG0] = t0_flag;
        ctl_rdata[CTL_RUN0]  = run0_q;
    end

    // R5
    t1_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t1_mode != MODE_13B && !wr_lo[1] && !wr_hi[1]) |=> $stable(t1_count));

    // R11
    t0_rsv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((t0_mode == MODE_RSV_A || t0_mode == MODE_RSV_B) && !wr_lo[0] && !wr_hi[0])
        |=> $stable(t0_count));

    // R7
    split_hi_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t0_split && t0_tick && run1_q && !wr_hi[0])
        |=> (hi_q[0] == $past(hi_q[0]) + BYTE_W'(1)));

    // R9
    ctl_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[3:0] == 4'b0);
endmodule

// File: tb/test_dual_tmr_unit.sv
module test_dual_tmr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [7:0]  ctl_rdata;
    logic        cnt_wr = 1'b0;
    logic [1:0]  cnt_sel = '0;
    logic [7:0]  cnt_wdata = '0;
    logic [1:0]  t0_mode = '0, t1_mode = '0;
    logic        t0_gate_en = 1'b0, t1_gate_en = 1'b0;
    logic        t0_pin = 1'b0, t1_pin = 1'b0;
    logic        t0_tick = 1'b0, t1_tick = 1'b0;
    logic        t0_ack = 1'b0, t1_ack = 1'b0;
    logic [15:0] t0_count, t1_count;
    logic        t0_flag, t1_flag;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_n = 0;

    always #2 clk = ~clk;  // 250 MHz

    dual_tmr_unit i_dual_tmr_unit (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .cnt_wr(cnt_wr), .cnt_sel(cnt_sel),
        .cnt_wdata(cnt_wdata), .t0_mode(t0_mode), .t1_mode(t1_mode),
        .t0_gate_en(t0_gate_en), .t1_gate_en(t1_gate_en), .t0_pin(t0_pin),
        .t1_pin(t1_pin), .t0_tick(t0_tick), .t1_tick(t1_tick),
        .t0_ack(t0_ack), .t1_ack(t1_ack), .t0_count(t0_count),
        .t1_count(t1_count), .t0_flag(t0_flag), .t1_flag(t1_flag)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failure.
    always @(posedge clk) begin
        cyc_n <= cyc_n + 1;
        if (cyc_n > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc_n);
            report();
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [7:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        cyc();
        ctl_wr = 1'b0;
    endtask

    task automatic cnt_write(input logic [1:0] s, input logic [7:0] v);
        cnt_wr = 1'b1; cnt_sel = s; cnt_wdata = v;
        cyc();
        cnt_wr = 1'b0;
    endtask

    function automatic int val13(input logic [15:0] c);
        return {c[15:8], c[4:0]};
    endfunction

    initial begin
        int base;
        int tl, th;
        bit f0, f1;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk("R1 t0_count", t0_count, 0);
        chk("R1 t1_count", t1_count, 0);
        chk("R1 ctl_rdata", ctl_rdata, 8'h00);

        // R2/R3: full 13-bit sweep on timer 0 with low-byte upper bits set
        ctl_write(8'h10);
        chk("R9 run0 bit4", ctl_rdata, 8'h10);
        cnt_write(2'd0, 8'hE0);
        cnt_write(2'd1, 8'h00);
        t0_tick = 1'b1;
        for (int i = 1; i <= 8192; i++) begin
            cyc();
            chk("R2 13-bit value", val13(t0_count), i % 8192);
            if (i == 8191) chk("R3 flag before wrap", t0_flag, 0);
            if (i == 8192) begin
                chk("R3 flag at wrap", t0_flag, 1);
                chk("R3 ctl bit5", ctl_rdata[5], 1);
            end
        end
        t0_tick = 1'b0;
        chk("R2 low-byte upper bits", t0_count[7:5], 3'b111);

        // R8 acknowledge clears flag
        t0_ack = 1'b1; cyc(); t0_ack = 1'b0;
        chk("R8 ack clears t0_flag", t0_flag, 0);

        // R4 gating sweep on timer 1, all run/gate/pin combinations
        t1_mode = 2'b00;
        for (int c = 0; c < 8; c++) begin
            logic [7:0] w;
            w = 8'h00; w[6] = c[2];
            ctl_write(w);
            t1_gate_en = c[1]; t1_pin = c[0];
            base = val13(t1_count);
            t1_tick = 1'b1;
            for (int k = 0; k < 5; k++) cyc();
            t1_tick = 1'b0;
            chk("R4 gated count delta", val13(t1_count) - base,
                (c[2] && (!c[1] || c[0])) ? 5 : 0);
        end
        t1_gate_en = 1'b0; t1_pin = 1'b0;

        // R5 timer 1 mode 11 holds; R11 timer 0 modes 01/10 hold
        ctl_write(8'h50);
        t1_mode = 2'b11; t0_mode = 2'b01;
        base = t1_count; tl = t0_count;
        t1_tick = 1'b1; t0_tick = 1'b1;
        for (int k = 0; k < 20; k++) cyc();
        chk("R5 t1 frozen in mode 11", t1_count, base);
        chk("R11 t0 holds in mode 01", t0_count, tl);
        t0_mode = 2'b10;
        for (int k = 0; k < 20; k++) cyc();
        t1_tick = 1'b0; t0_tick = 1'b0;
        chk("R11 t0 holds in mode 10", t0_count, tl);

        // R6/R7 split mode sweep
        t0_mode = 2'b11;
        ctl_write(8'h50);
        cnt_write(2'd0, 8'hF0);
        cnt_write(2'd1, 8'hE0);
        t0_gate_en = 1'b1; t0_pin = 1'b0;
        t0_tick = 1'b1;
        for (int k = 0; k < 10; k++) cyc();
        chk("R6 gated low byte holds", t0_count[7:0], 8'hF0);
        chk("R7 high byte ignores gate", t0_count[15:8], 8'hEA);
        t0_pin = 1'b1;
        tl = 8'hF0; th = 8'hEA; f0 = 0; f1 = 0;
        for (int k = 0; k < 300; k++) begin
            cyc();
            if (tl == 255) f0 = 1;
            if (th == 255) f1 = 1;
            tl = (tl + 1) % 256; th = (th + 1) % 256;
            chk("R6 split low byte", t0_count[7:0], tl);
            chk("R7 split high byte", t0_count[15:8], th);
            chk("R6 t0_flag", t0_flag, int'(f0));
            chk("R7 t1_flag", t1_flag, int'(f1));
        end
        t0_tick = 1'b0;
        // R7 high byte needs timer 1 run
        ctl_write(8'h10);
        th = t0_count[15:8];
        t0_tick = 1'b1; cyc(); cyc(); t0_tick = 1'b0;
        chk("R7 high byte stops without run1", t0_count[15:8], th);

        // R10 hardware set beats software clear
        ctl_write(8'h50);
        cnt_write(2'd0, 8'hFF);
        ctl_wr = 1'b1; ctl_wdata = 8'h50; t0_tick = 1'b1;
        cyc();
        ctl_wr = 1'b0; t0_tick = 1'b0;
        chk("R10 flag kept on collision", t0_flag, 1);
        chk("R10 low byte wrapped", t0_count[7:0], 8'h00);

        // R9 software clear, set and low bits
        ctl_write(8'h50);
        chk("R9 write clears flags", ctl_rdata, 8'h50);
        ctl_write(8'hF0);
        chk("R9 write sets flags", ctl_rdata, 8'hF0);
        ctl_write(8'h5F);
        chk("R9 low bits read zero", ctl_rdata, 8'h50);

        // R12 write beats count; R3 on timer 1
        t1_mode = 2'b00; t1_gate_en = 1'b0;
        cnt_write(2'd3, 8'h33);
        cnt_wr = 1'b1; cnt_sel = 2'd2; cnt_wdata = 8'h1A; t1_tick = 1'b1;
        cyc();
        cnt_wr = 1'b0; t1_tick = 1'b0;
        chk("R12 write priority", t1_count, 16'h331A);
        cnt_write(2'd3, 8'hFF);
        cnt_write(2'd2, 8'h1F);
        t1_tick = 1'b1; cyc(); t1_tick = 1'b0;
        chk("R3 t1 wrap value", val13(t1_count), 0);
        chk("R3 t1 flag bit7", ctl_rdata[7], 1);
        t1_ack = 1'b1; cyc(); t1_ack = 1'b0;
        chk("R8 ack clears t1_flag", t1_flag, 0);

        report();
    end
endmodule